// File: doc/BRIEF.md
# Request-Driven Descriptor Transfer Engine

This block moves one data item each time a peripheral raises a request line, with no processor involvement per item. Every request source owns a slot in a vector table in memory. The slot address is the vector base input plus a fixed per-source offset. The slot holds a pointer to a four-longword descriptor that carries all of that source's channel state: the mode bytes, the source address, the destination address and two 16-bit counts. On activation, the engine reads the slot and fetches the descriptor. It then reads one item of byte, word or longword size from the source address and writes it to the destination address. Finally it steps the addresses and the count and writes the changed words back. All memory traffic goes through one simple 32-bit master port.

After each transfer the engine either pulses a clear back to the requesting peripheral or hands the request to the processor as an interrupt. A request is handed over after the last transfer of a run, or after every transfer when the descriptor selects per-transfer interrupts. A handed-over source is not served again until its request line drops. When several sources are pending, they are served one at a time, lowest index (lowest vector offset) first. Only normal single-transfer operation is supported. The mode field and the chain bit are read but have no effect.

The control sequence has seven named states:
- IDLE: arbitration.
- VEC: vector read.
- FETCH: four descriptor reads.
- READ: source read.
- WRITE: destination write.
- STORE: write-back of descriptor words 1 to 3.
- FINISH: clear or hand-over.

The transitions are:
- IDLE→VEC when an eligible request exists.
- VEC→FETCH on acknowledge.
- FETCH→FETCH on each of the first three acknowledges, then FETCH→READ on the fourth.
- READ→WRITE on acknowledge.
- WRITE→STORE on acknowledge.
- STORE→STORE on each of the first two acknowledges, then STORE→FINISH on the third.
- FINISH→IDLE unconditionally.

Top module: `dte_engine`

## Requirements
- R1: The vector slot of source i is read as a longword at (vec_base + 0x764 + 4*i) with bits [1:0] forced to 0. The descriptor pointer read from the slot also has its bits [1:0] forced to 0 before use.
- R2: The descriptor is read as four longwords at pointer +0, +4, +8 and +12. Word 0 bits [31:24] are mode A and bits [23:16] are mode B. Word 1 is the source address and word 2 is the destination address. Word 3 bits [31:16] are count A and bits [15:0] are count B.
- R3: The mode A size field (bits [5:4]) selects the transfer size: 00 byte, 01 word, 10 longword (11 is taken as longword). One item of that size is read at the source address and written unchanged to the destination address. mem_size carries 0, 1 or 2 respectively, and mem_rdata and mem_wdata are right-aligned. Bytes beyond the item size are not written.
- R4: The source control (mode A bits [3:2]) and the destination control (mode B bits [3:2]) each select the address behaviour: 10 increments the address by the item size (1, 2 or 4) after the transfer, and any other value keeps it fixed.
- R5: After each transfer, descriptor words 1, 2 and 3 are written back with the updated addresses and count A minus 1. Count B is written back unchanged, and word 0 is never written.
- R6: A count A of 0 stands for 65,536 transfers. After one transfer it is written back as 0xFFFF, and that transfer is not the last.
- R7: With the interrupt-select bit (mode B bit 5) at 0, a transfer that starts with count A other than 1 ends with a one-cycle src_clr pulse for that source and no interrupt. A transfer that starts with count A equal to 1 instead raises cpu_irq for that source and gives no clear.
- R8: With the interrupt-select bit at 1, every transfer raises cpu_irq for the source and gives no clear.
- R9: cpu_irq for a source stays high until that source's request line is low, and drops the cycle after. While it is high, the source is not served again.
- R10: A source whose src_en bit is 0 is never served, whatever its request line does. It is served once the bit is set.
- R11: When several eligible requests are pending, the lowest source index is served first and each is served completely before the next.
- R12: Once mem_req is raised, mem_req, mem_addr and mem_we stay unchanged until the cycle in which mem_ack is seen.
- R13: After reset, mem_req, src_clr and cpu_irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_req | input | NSRC | Request lines from peripherals, level held until cleared |
| src_en | input | NSRC | Per-source activation enable |
| vec_base | input | 32 | Vector table base address |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_size | output | 2 | 0 byte, 1 word, 2 longword |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_rdata | input | 32 | Right-aligned read data, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the pending access |
| src_clr | output | NSRC | One-cycle request clear to the peripheral |
| cpu_irq | output | NSRC | Request handed to the processor |

## Verification
The checks on clears and hand-over assume that a peripheral drops its request in the same edge that samples src_clr. They also assume that it keeps its request high until either cleared or released by the processor. The bench's peripheral model obeys this exactly. The handshake checks assume that memory answers each access with exactly one mem_ack pulse and that it never acknowledges while no request is pending. The bench memory holds a one-cycle acknowledge rule and inserts extra wait states in some scenarios so that held requests are exercised.

// File: rtl/dte_pkg.sv
package dte_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_VEC,
        S_FETCH,
        S_READ,
        S_WRITE,
        S_STORE,
        S_FINISH
    } dte_state_e;

    // item size codes carried on mem_size
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_WORD = 2'd1;
    localparam logic [1:0] SZ_LONG = 2'd2;

    // address control code that means "step after transfer"
    localparam logic [1:0] AC_STEP = 2'b10;

    // bit positions inside descriptor word 0
    localparam int MA_LSB   = 24;   // mode A byte
    localparam int MB_LSB   = 16;   // mode B byte
    localparam int SZ_LSB   = MA_LSB + 4;
    localparam int SCTL_LSB = MA_LSB + 2;
    localparam int DCTL_LSB = MB_LSB + 2;
    localparam int ISEL_BIT = MB_LSB + 5;

    function automatic logic [1:0] eff_size(input logic [1:0] code);
        return (code == 2'b11) ? SZ_LONG : code;
    endfunction

    function automatic logic [31:0] size_mask(input logic [31:0] d, input logic [1:0] sz);
        logic [31:0] r;
        unique case (sz)
            SZ_BYTE: r = {24'h0, d[7:0]};
            SZ_WORD: r = {16'h0, d[15:0]};
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dte_arbiter.sv
module dte_arbiter #(
    parameter int NSRC = 4,
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0] cand,
    output logic            valid,
    output logic [IW-1:0]   idx
);
    // lowest index wins: scan downward so the last hit is the smallest
    always_comb begin
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (cand[i]) idx = IW'(i);
        end
    end

    assign valid = |cand;

endmodule

// File: rtl/dte_addr_unit.sv
module dte_addr_unit
    import dte_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] cur,
    input  logic [1:0]    size_code,
    input  logic [1:0]    ctrl,
    output logic [AW-1:0] nxt
);
    logic [2:0] step;

    always_comb begin
        unique case (eff_size(size_code))
            SZ_BYTE: step = 3'd1;
            SZ_WORD: step = 3'd2;
            default: step = 3'd4;
        endcase
    end

    assign nxt = (ctrl == AC_STEP) ? cur + AW'(step) : cur;

endmodule

// File: rtl/dte_sequencer.sv
module dte_sequencer
    import dte_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       grant_valid,
    input  logic       mem_ack,
    output dte_state_e state_o,
    output logic [1:0] beat_o,
    output logic       mem_req,
    output logic       mem_we,
    output logic       long_acc
);
    dte_state_e state_q, state_d;
    logic [1:0] beat_q, beat_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        unique case (state_q)
            S_IDLE: begin
                if (grant_valid) state_d = S_VEC;
            end
            S_VEC: begin
                if (mem_ack) begin
                    state_d = S_FETCH;
                    beat_d  = 2'd0;
                end
            end
            S_FETCH: begin
                if (mem_ack) begin
                    if (beat_q == 2'd3) state_d = S_READ;
                    else                beat_d  = beat_q + 2'd1;
                end
            end
            S_READ: begin
                if (mem_ack) state_d = S_WRITE;
            end
            S_WRITE: begin
                if (mem_ack) begin
                    state_d = S_STORE;
                    beat_d  = 2'd1;   // word 0 is not written back
                end
            end
            S_STORE: begin
                if (mem_ack) begin
                    if (beat_q == 2'd3) state_d = S_FINISH;
                    else                beat_d  = beat_q + 2'd1;
                end
            end
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        long_acc = 1'b1;
        unique case (state_q)
            S_VEC, S_FETCH: mem_req = 1'b1;
            S_READ: begin
                mem_req  = 1'b1;
                long_acc = 1'b0;
            end
            S_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                long_acc = 1'b0;
            end
            S_STORE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
    assign beat_o  = beat_q;

endmodule

// File: rtl/dte_engine.sv
module dte_engine
    import dte_pkg::*;
#(
    parameter int          NSRC      = 4,
    parameter logic [31:0] VEC_FIRST = 32'h0000_0764,
    parameter int          VEC_STEP  = 4,
    parameter int          CNT_W     = 16,
    localparam int         IW        = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_req,
    input  logic [NSRC-1:0] src_en,
    input  logic [31:0]     vec_base,
    output logic            mem_req,
    output logic            mem_we,
    output logic [1:0]      mem_size,
    output logic [31:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    output logic [NSRC-1:0] src_clr,
    output logic [NSRC-1:0] cpu_irq
);
    dte_state_e       state;
    logic [1:0]       beat;
    logic             long_acc;
    logic             grant_valid;
    logic [IW-1:0]    grant_idx;
    logic [NSRC-1:0]  handed_q;
    logic [NSRC-1:0]  cand;

    // per-activation working copy of the descriptor
    logic [IW-1:0]    sel_q;
    logic [31:0]      dptr_q;
    logic [31:0]      word0_q;
    logic [31:0]      sar_q;
    logic [31:0]      dar_q;
    logic [CNT_W-1:0] cnt_a_q;
    logic [CNT_W-1:0] cnt_b_q;
    logic [31:0]      item_q;
    logic             last_q;

    logic [1:0]       xsize;
    logic [31:0]      sar_nx;
    logic [31:0]      dar_nx;
    logic [31:0]      vec_addr;
    logic [31:0]      dsc_addr;
    logic             hand_over;

    assign cand = src_req & src_en & ~handed_q;

    dte_arbiter #(.NSRC(NSRC)) u_arb (
        .cand  (cand),
        .valid (grant_valid),
        .idx   (grant_idx)
    );

    dte_sequencer u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .grant_valid (grant_valid),
        .mem_ack     (mem_ack),
        .state_o     (state),
        .beat_o      (beat),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .long_acc    (long_acc)
    );

    assign xsize = eff_size(word0_q[SZ_LSB +: 2]);

    dte_addr_unit u_src_step (
        .cur       (sar_q),
        .size_code (xsize),
        .ctrl      (word0_q[SCTL_LSB +: 2]),
        .nxt       (sar_nx)
    );

    dte_addr_unit u_dst_step (
        .cur       (dar_q),
        .size_code (xsize),
        .ctrl      (word0_q[DCTL_LSB +: 2]),
        .nxt       (dar_nx)
    );

    // slot and descriptor addresses, both longword aligned
    assign vec_addr = (vec_base + VEC_FIRST + 32'(sel_q) * 32'(VEC_STEP)) & ~32'h3;
    assign dsc_addr = dptr_q + {28'h0, beat, 2'b00};

    always_comb begin
        unique case (state)
            S_VEC:            mem_addr = vec_addr;
            S_FETCH, S_STORE: mem_addr = dsc_addr;
            S_READ:           mem_addr = sar_q;
            S_WRITE:          mem_addr = dar_q;
            default:          mem_addr = '0;
        endcase
    end

    assign mem_size = long_acc ? SZ_LONG : xsize;

    always_comb begin
        mem_wdata = '0;
        if (state == S_WRITE) begin
            mem_wdata = item_q;
        end else if (state == S_STORE) begin
            unique case (beat)
                2'd1:    mem_wdata = sar_q;
                2'd2:    mem_wdata = dar_q;
                default: mem_wdata = {cnt_a_q, cnt_b_q};
            endcase
        end
    end

    // datapath captures
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q   <= '0;
            dptr_q  <= '0;
            word0_q <= '0;
            sar_q   <= '0;
            dar_q   <= '0;
            cnt_a_q <= '0;
            cnt_b_q <= '0;
            item_q  <= '0;
            last_q  <= 1'b0;
        end else begin
            if (state == S_IDLE && grant_valid) sel_q <= grant_idx;
            if (mem_ack) begin
                unique case (state)
                    S_VEC: dptr_q <= mem_rdata & ~32'h3;
                    S_FETCH: begin
                        unique case (beat)
                            2'd0: word0_q <= mem_rdata;
                            2'd1: sar_q   <= mem_rdata;
                            2'd2: dar_q   <= mem_rdata;
                            default: begin
                                cnt_a_q <= mem_rdata[31:16];
                                cnt_b_q <= mem_rdata[15:0];
                            end
                        endcase
                    end
                    S_READ: item_q <= size_mask(mem_rdata, xsize);
                    S_WRITE: begin
                        sar_q   <= sar_nx;
                        dar_q   <= dar_nx;
                        last_q  <= (cnt_a_q == CNT_W'(1));
                        cnt_a_q <= cnt_a_q - CNT_W'(1);   // 0 wraps: 65,536 runs
                    end
                    default: ;
                endcase
            end
        end
    end

    assign hand_over = word0_q[ISEL_BIT] | last_q;

    // per-source hand-over flags and clear pulses
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic fin_here;
        assign fin_here = (state == S_FINISH) && (sel_q == IW'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      handed_q[g] <= 1'b0;
            else if (fin_here && hand_over)  handed_q[g] <= 1'b1;
            else if (!src_req[g])            handed_q[g] <= 1'b0;
        end

        assign src_clr[g] = fin_here && !hand_over;
    end

    assign cpu_irq = handed_q;

endmodule

// File: rtl/dte_engine_chk.sv
module dte_engine_chk #(
    parameter int NSRC = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] src_req,
    input logic [NSRC-1:0] src_en,
    input logic            mem_req,
    input logic            mem_we,
    input logic [31:0]     mem_addr,
    input logic            mem_ack,
    input logic [NSRC-1:0] src_clr,
    input logic [NSRC-1:0] cpu_irq
);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R11
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_clr));

    // R10
    clr_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_clr) |-> ((src_clr & ~(src_req & src_en)) == '0));

    // R7
    clr_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_clr) |-> !mem_req);

    // R9
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cpu_irq) & ~cpu_irq & $past(src_req)) == '0));

    // R8
    irq_no_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((src_clr & cpu_irq) == '0));

endmodule

bind dte_engine dte_engine_chk #(.NSRC(NSRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .src_en   (src_en),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_ack  (mem_ack),
    .src_clr  (src_clr),
    .cpu_irq  (cpu_irq)
);

// File: tb/tb_dte_engine.sv
module tb_dte_engine;
    localparam int NSRC = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic [NSRC-1:0] src_req, src_en, raise, drop;
    logic [31:0]     vec_base;
    logic            mem_req, mem_we, mem_ack;
    logic [1:0]      mem_size;
    logic [31:0]     mem_addr, mem_wdata, mem_rdata;
    logic [NSRC-1:0] src_clr, cpu_irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;
    bit slow = 0;
    int addr_viol = 0;

    dte_engine #(.NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en),
        .vec_base(vec_base), .mem_req(mem_req), .mem_we(mem_we),
        .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .src_clr(src_clr),
        .cpu_irq(cpu_irq)
    );

    // byte memory, 4 KiB window
    logic [7:0] mem [0:4095];
    logic       pend;
    logic [1:0] wcnt;
    logic [31:0] pend_addr;

    function automatic int nbytes(input logic [1:0] s);
        return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
    endfunction

    function automatic logic [31:0] rdm(input logic [31:0] a, input logic [1:0] s);
        logic [31:0] r = '0;
        for (int k = 0; k < nbytes(s); k++) r[8*k +: 8] = mem[(a + k) & 32'hfff];
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0; pend <= 1'b0; wcnt <= 2'd0; mem_rdata <= '0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (pend && mem_addr != pend_addr) addr_viol <= addr_viol + 1;
            if ((!pend && !slow) || (pend && wcnt == 2'd0)) begin
                pend    <= 1'b0;
                mem_ack <= 1'b1;
                if (mem_we) begin
                    for (int k = 0; k < nbytes(mem_size); k++)
                        mem[(mem_addr + k) & 32'hfff] <= mem_wdata[8*k +: 8];
                end else begin
                    mem_rdata <= rdm(mem_addr, mem_size);
                end
            end else if (!pend) begin
                pend <= 1'b1; pend_addr <= mem_addr; wcnt <= 2'd2;
            end else begin
                wcnt <= wcnt - 2'd1;
            end
        end
    end

    // peripheral request flags
    always @(posedge clk) begin
        if (!rst_n) src_req <= '0;
        else        src_req <= (src_req | raise) & ~src_clr & ~drop;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return rdm(a, 2'd2);
    endfunction

    task automatic wr32(input logic [31:0] a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[(a + k) & 32'hfff] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] dbase(input int i);
        return 32'h800 + 32'(16 * i);
    endfunction

    task automatic set_desc(input int i, input logic [7:0] ma, input logic [7:0] mb,
                            input logic [31:0] s, input logic [31:0] d,
                            input logic [15:0] ca, input logic [15:0] cb);
        // vector slot with low pointer bits set to exercise alignment
        wr32(32'h764 + 32'(4 * i), dbase(i) + 32'h1);
        wr32(dbase(i) + 0,  {ma, mb, 16'h5A5A});
        wr32(dbase(i) + 4,  s);
        wr32(dbase(i) + 8,  d);
        wr32(dbase(i) + 12, {ca, cb});
    endtask

    task automatic fire(input int i);
        @(negedge clk) raise[i] = 1'b1;
        @(negedge clk) raise = '0;
    endtask

    task automatic release_src(input int i);
        @(negedge clk) drop[i] = 1'b1;
        @(negedge clk) drop = '0;
        @(negedge clk);
    endtask

    task automatic wait_done(input int i, output bit got_irq, output bit got_any);
        got_irq = 0; got_any = 0;
        for (int n = 0; n < 400; n++) begin
            @(negedge clk);
            if (src_clr[i]) begin got_any = 1; break; end
            if (cpu_irq[i]) begin got_any = 1; got_irq = 1; break; end
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(mem_req == 1'b0, "R13 mem_req", 32'(mem_req), 0);
        check(src_clr == '0, "R13 src_clr", 32'(src_clr), 0);
        check(cpu_irq == '0, "R13 cpu_irq", 32'(cpu_irq), 0);
    endtask

    task automatic t_byte_run;
        logic [7:0] pat [3] = '{8'h11, 8'h22, 8'h33};
        bit irq, any;
        set_desc(0, 8'h08, 8'h00, 32'h900, 32'hA00, 16'd3, 16'h1234);
        for (int k = 0; k < 3; k++) mem[32'h900 + k] = pat[k];
        mem[32'hA01] = 8'hEE;
        for (int k = 0; k < 3; k++) begin
            fire(0);
            wait_done(0, irq, any);
            check(any, "R1 source 0 served via aligned slot/pointer", 32'(any), 1);
            check(irq == (k == 2), "R7 clear vs interrupt by count", 32'(irq), 32'(k == 2));
            check(mem[32'hA00] == pat[k], "R3 byte moved", 32'(mem[32'hA00]), 32'(pat[k]));
        end
        check(mem[32'hA01] == 8'hEE, "R3 byte size writes one byte", 32'(mem[32'hA01]), 32'hEE);
        check(rd32(dbase(0) + 4) == 32'h903, "R4 source incremented by 1", rd32(dbase(0) + 4), 32'h903);
        check(rd32(dbase(0) + 8) == 32'hA00, "R4 destination fixed", rd32(dbase(0) + 8), 32'hA00);
        check(rd32(dbase(0) + 12) == 32'h0000_1234, "R5 count A and count B written back",
              rd32(dbase(0) + 12), 32'h0000_1234);
        check(rd32(dbase(0)) == 32'h0800_5A5A, "R2 word 0 untouched", rd32(dbase(0)), 32'h0800_5A5A);
        check(cpu_irq[0] == 1'b1, "R9 interrupt held", 32'(cpu_irq[0]), 1);
        release_src(0);
        check(cpu_irq[0] == 1'b0, "R9 interrupt drops after request", 32'(cpu_irq[0]), 0);
    endtask

    task automatic t_word_run;
        bit irq, any;
        slow = 1;
        set_desc(1, 8'h10, 8'h08, 32'hA10, 32'h920, 16'd2, 16'h0007);
        mem[32'hA10] = 8'hEF; mem[32'hA11] = 8'hBE;
        wr32(32'h920, 32'h0); wr32(32'h924, 32'h0);
        fire(1); wait_done(1, irq, any);
        check(any && !irq, "R7 first word transfer cleared", 32'(irq), 0);
        mem[32'hA10] = 8'h34; mem[32'hA11] = 8'h12;
        fire(1); wait_done(1, irq, any);
        check(irq, "R7 final transfer interrupts", 32'(irq), 1);
        check(rd32(32'h920) == 32'h1234_BEEF, "R3 word items placed", rd32(32'h920), 32'h1234_BEEF);
        check(rd32(32'h924) == 32'h0, "R3 no bytes past item", rd32(32'h924), 0);
        check(rd32(dbase(1) + 8) == 32'h924, "R4 destination incremented by 2", rd32(dbase(1) + 8), 32'h924);
        check(rd32(dbase(1) + 4) == 32'hA10, "R4 source fixed", rd32(dbase(1) + 4), 32'hA10);
        release_src(1);
        slow = 0;
    endtask

    task automatic t_long_zero;
        bit irq, any;
        set_desc(2, 8'h28, 8'h08, 32'h940, 32'h960, 16'd0, 16'hBEAD);
        wr32(32'h940, 32'hCAFE_F00D);
        fire(2); wait_done(2, irq, any);
        check(any && !irq, "R6 count 0 not last", 32'(irq), 0);
        check(rd32(dbase(2) + 12) == 32'hFFFF_BEAD, "R6 count 0 becomes FFFF",
              rd32(dbase(2) + 12), 32'hFFFF_BEAD);
        check(rd32(32'h960) == 32'hCAFE_F00D, "R3 longword moved", rd32(32'h960), 32'hCAFE_F00D);
        check(rd32(dbase(2) + 4) == 32'h944, "R4 source incremented by 4", rd32(dbase(2) + 4), 32'h944);
        check(rd32(dbase(2) + 8) == 32'h964, "R4 destination incremented by 4", rd32(dbase(2) + 8), 32'h964);
    endtask

    task automatic t_isel;
        bit irq, any;
        set_desc(3, 8'h00, 8'h20, 32'hA20, 32'h980, 16'd5, 16'h0);
        mem[32'hA20] = 8'h77;
        fire(3); wait_done(3, irq, any);
        check(irq, "R8 per-transfer interrupt", 32'(irq), 1);
        check(rd32(dbase(3) + 12) == 32'h0004_0000, "R8 count after one", rd32(dbase(3) + 12), 32'h0004_0000);
        repeat (40) @(negedge clk);
        check(cpu_irq[3] == 1'b1, "R9 interrupt stays while request high", 32'(cpu_irq[3]), 1);
        check(rd32(dbase(3) + 12) == 32'h0004_0000, "R9 no reactivation while handed over",
              rd32(dbase(3) + 12), 32'h0004_0000);
        release_src(3);
        check(cpu_irq[3] == 1'b0, "R9 interrupt released", 32'(cpu_irq[3]), 0);
    endtask

    task automatic t_enable;
        bit irq, any, seen;
        set_desc(1, 8'h00, 8'h08, 32'hA30, 32'h9A0, 16'd4, 16'h0);
        mem[32'hA30] = 8'h5C; mem[32'h9A0] = 8'h00;
        src_en[1] = 1'b0;
        fire(1);
        seen = 0;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            if (src_clr[1] || cpu_irq[1]) seen = 1;
        end
        check(!seen, "R10 disabled source not served", 32'(seen), 0);
        check(rd32(dbase(1) + 12) == 32'h0004_0000, "R10 descriptor untouched while disabled",
              rd32(dbase(1) + 12), 32'h0004_0000);
        check(mem[32'h9A0] == 8'h00, "R10 no data moved while disabled", 32'(mem[32'h9A0]), 0);
        src_en[1] = 1'b1;
        wait_done(1, irq, any);
        check(any && !irq, "R10 served once enabled", 32'(any), 1);
        check(mem[32'h9A0] == 8'h5C, "R10 data moved once enabled", 32'(mem[32'h9A0]), 32'h5C);
    endtask

    task automatic t_priority;
        int order [2];
        int got = 0;
        set_desc(0, 8'h00, 8'h00, 32'hA40, 32'hA41, 16'd10, 16'h0);
        set_desc(2, 8'h00, 8'h00, 32'hA42, 32'hA43, 16'd10, 16'h0);
        @(negedge clk) raise = 4'b0101;
        @(negedge clk) raise = '0;
        for (int n = 0; n < 400 && got < 2; n++) begin
            @(negedge clk);
            for (int i = 0; i < NSRC; i++) if (src_clr[i]) begin order[got] = i; got++; end
        end
        check(got == 2, "R11 both served", 32'(got), 2);
        check(order[0] == 0, "R11 lowest index first", 32'(order[0]), 0);
        check(order[1] == 2, "R11 higher index second", 32'(order[1]), 2);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        rst_n = 1'b0; raise = '0; drop = '0; src_en = '1; vec_base = 32'h2;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_run();
        t_word_run();
        t_long_zero();
        t_isel();
        t_enable();
        t_priority();
        check(addr_viol == 0, "R12 address held until acknowledge", 32'(addr_viol), 0);
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule